// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block sits in the middle of an eight-line interrupt controller. Each cycle it masks the pending-request vector, scans the survivors from a rotatable priority base, and compares the best candidate against the most urgent line that is already in service. The interrupt output rises only when the candidate is strictly more urgent. The winning line number goes out beside it, and the in-service register is a port so that the vector logic and the read path can use it.

The block also owns the in-service register and the priority base. A command byte written through a strobe retires in-service lines, either the most urgent one or a named one, and can move the priority base. An acknowledge strobe marks the acknowledged line as in service, unless automatic end-of-interrupt is selected. If rotation on automatic end-of-interrupt is on, the acknowledge also moves the base to just past that line. The initialisation sequencer outside the block supplies the automatic end-of-interrupt enable and the special nested mode enable as static inputs.

Top module: `irq_prio_resolver`

## Requirements
- R1: Priority positions 0..7 are scanned in order, and position p tests line (p + base) mod 8. The first candidate found wins, and `win_line_o` reports that line.
- R2: Candidates are `pend_i & ~mask_i`. A masked line never wins.
- R3: The in-service priority is found with the same rotated scan over `isr_o`. `irq_o` is high only when the candidate's position is strictly lower than that priority, with no in-service bit counting as position 8. `win_line_o` is 0 whenever `irq_o` is low.
- R4: When `sfn_en_i` is high on the primary instance, in-service line 2 (the cascade input) is left out of the in-service priority.
- R5: The command code is `cmd_data_i[7:5]`. Code 1 clears the in-service bit of the most urgent in-service line under the current base. It does nothing when no bit is set.
- R6: Code 5 acts as code 1 and then sets the base to (cleared line + 1) mod 8. When no bit is set it changes nothing.
- R7: Code 3 clears in-service bit `cmd_data_i[2:0]`. Code 7 does the same and also sets the base to (`cmd_data_i[2:0]` + 1) mod 8.
- R8: Code 6 sets the base to (`cmd_data_i[2:0]` + 1) mod 8 and leaves the in-service register alone. Code 2 has no effect on the outputs.
- R9: Code 4 turns rotation-on-automatic-EOI on and code 0 turns it off. While it is on, an acknowledge sets the base to (`ack_line_i` + 1) mod 8.
- R10: An acknowledge sets in-service bit `ack_line_i` when `aeoi_en_i` is low. When `aeoi_en_i` is high, the acknowledge leaves the in-service register unchanged.
- R11: If a command and an acknowledge arrive in the same cycle, the command's clear is applied first and the acknowledge's set second. An acknowledge rotation overrides a base change from the command, and the acknowledge uses the rotation flag as it stood before the command.
- R12: Reset clears the in-service register and the rotation flag and sets the base to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 8 | Pending-request vector |
| mask_i | input | 8 | Mask register, 1 blocks a line |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_data_i | input | 8 | Command byte |
| ack_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | 3 | Line being acknowledged |
| aeoi_en_i | input | 1 | Automatic end-of-interrupt enable |
| sfn_en_i | input | 1 | Special nested mode enable |
| irq_o | output | 1 | Interrupt request output |
| win_line_o | output | 3 | Winning line number |
| isr_o | output | 8 | In-service register |

## Verification
The base register is hidden, so a wrong base shows only through `win_line_o`. That becomes visible in the first cycle after the bad update in which two or more candidates are pending. A stale or wrongly cleared in-service bit shows at once on `isr_o`. It then shows through `irq_o` on any later cycle that has a request of lower urgency. Random command, acknowledge and mode traffic is run against a reference model so that these divergences show up within a cycle of the faulty update. Directed sequences cover rotation, nested mode and the empty end-of-interrupt cases.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NLINES = 8;
  localparam int LW     = $clog2(NLINES);
  localparam int PW     = LW + 1;

  typedef enum logic [2:0] {
    CMD_ROT_OFF = 3'd0,
    CMD_EOI_ANY = 3'd1,
    CMD_NOP     = 3'd2,
    CMD_EOI_ONE = 3'd3,
    CMD_ROT_ON  = 3'd4,
    CMD_EOI_ROT = 3'd5,
    CMD_SET_PRI = 3'd6,
    CMD_ONE_ROT = 3'd7
  } cmd_code_e;

  // Rotated scan: position p looks at line (p + base) mod NLINES.
  // Returns NLINES when nothing is set.
  function automatic logic [PW-1:0] scan_prio(logic [NLINES-1:0] v, logic [LW-1:0] base);
    logic [PW-1:0] r;
    r = PW'(NLINES);
    for (int p = NLINES - 1; p >= 0; p--) begin
      if (v[LW'(p) + base]) r = PW'(p);
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] prio_to_line(logic [PW-1:0] prio, logic [LW-1:0] base);
    return prio[LW-1:0] + base;
  endfunction
endpackage

// File: rtl/irqr_find.sv
module irqr_find
  import irqr_pkg::*;
(
  input  logic [NLINES-1:0] vec_i,
  input  logic [LW-1:0]     base_i,
  output logic [PW-1:0]     prio_o,
  output logic              hit_o,
  output logic [LW-1:0]     line_o
);
  always_comb begin
    prio_o = scan_prio(vec_i, base_i);
    hit_o  = (prio_o != PW'(NLINES));
    line_o = prio_to_line(prio_o, base_i);
  end
endmodule

// File: rtl/irqr_cmd.sv
module irqr_cmd
  import irqr_pkg::*;
(
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              isr_hit_i,
  input  logic [LW-1:0]     isr_line_i,
  output logic [NLINES-1:0] eoi_clr_o,
  output logic              base_ld_o,
  output logic [LW-1:0]     base_val_o,
  output logic              rot_ld_o,
  output logic              rot_val_o
);
  cmd_code_e     code;
  logic [LW-1:0] arg;

  always_comb begin
    code       = cmd_code_e'(cmd_data_i[7:5]);
    arg        = cmd_data_i[LW-1:0];
    eoi_clr_o  = '0;
    base_ld_o  = 1'b0;
    base_val_o = '0;
    rot_ld_o   = 1'b0;
    rot_val_o  = 1'b0;
    if (cmd_we_i) begin
      unique case (code)
        CMD_EOI_ANY, CMD_EOI_ROT: begin
          if (isr_hit_i) begin
            eoi_clr_o[isr_line_i] = 1'b1;
            base_ld_o  = (code == CMD_EOI_ROT);
            base_val_o = isr_line_i + LW'(1);
          end
        end
        CMD_EOI_ONE, CMD_ONE_ROT: begin
          eoi_clr_o[arg] = 1'b1;
          base_ld_o  = (code == CMD_ONE_ROT);
          base_val_o = arg + LW'(1);
        end
        CMD_SET_PRI: begin
          base_ld_o  = 1'b1;
          base_val_o = arg + LW'(1);
        end
        CMD_ROT_OFF, CMD_ROT_ON: begin
          rot_ld_o  = 1'b1;
          rot_val_o = (code == CMD_ROT_ON);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irqr_pkg::*;
#(
  parameter bit      IS_PRIMARY   = 1'b1,
  parameter int      CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        pend_i,
  input  logic [7:0]        mask_i,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              ack_i,
  input  logic [2:0]        ack_line_i,
  input  logic              aeoi_en_i,
  input  logic              sfn_en_i,
  output logic              irq_o,
  output logic [2:0]        win_line_o,
  output logic [7:0]        isr_o
);
  logic [NLINES-1:0] isr_q, isr_d;
  logic [LW-1:0]     base_q, base_d;
  logic              rot_q, rot_d;

  // Named internal events
  logic [NLINES-1:0] cand_vec, cmp_vec, eoi_clr, ack_set;
  logic [PW-1:0]     req_prio, cmp_prio, isr_prio;
  logic              req_hit, cmp_hit, isr_hit;
  logic [LW-1:0]     req_line, cmp_line, isr_line;
  logic              base_ld, rot_ld, rot_val, ack_rotate;
  logic [LW-1:0]     base_val;

  assign cand_vec = pend_i & ~mask_i;

  always_comb begin
    cmp_vec = isr_q;
    if (IS_PRIMARY && sfn_en_i) cmp_vec[CASCADE_LINE] = 1'b0;
  end

  irqr_find u_req (.vec_i(cand_vec), .base_i(base_q),
                   .prio_o(req_prio), .hit_o(req_hit), .line_o(req_line));
  irqr_find u_cmp (.vec_i(cmp_vec),  .base_i(base_q),
                   .prio_o(cmp_prio), .hit_o(cmp_hit), .line_o(cmp_line));
  irqr_find u_isr (.vec_i(isr_q),    .base_i(base_q),
                   .prio_o(isr_prio), .hit_o(isr_hit), .line_o(isr_line));

  irqr_cmd u_cmd (
    .cmd_we_i  (cmd_we_i),
    .cmd_data_i(cmd_data_i),
    .isr_hit_i (isr_hit),
    .isr_line_i(isr_line),
    .eoi_clr_o (eoi_clr),
    .base_ld_o (base_ld),
    .base_val_o(base_val),
    .rot_ld_o  (rot_ld),
    .rot_val_o (rot_val)
  );

  always_comb begin
    ack_set = '0;
    if (ack_i && !aeoi_en_i) ack_set[ack_line_i] = 1'b1;
  end
  assign ack_rotate = ack_i && rot_q;

  always_comb begin
    isr_d  = (isr_q & ~eoi_clr) | ack_set;
    base_d = base_q;
    if (ack_rotate)   base_d = ack_line_i + LW'(1);
    else if (base_ld) base_d = base_val;
    rot_d  = rot_ld ? rot_val : rot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
      rot_q  <= rot_d;
    end
  end

  assign irq_o      = req_hit && (req_prio < cmp_prio);
  assign win_line_o = irq_o ? req_line : '0;
  assign isr_o      = isr_q;
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pend_i,
  input logic [7:0] mask_i,
  input logic       cmd_we_i,
  input logic [7:0] cmd_data_i,
  input logic       ack_i,
  input logic [2:0] ack_line_i,
  input logic       aeoi_en_i,
  input logic       sfn_en_i,
  input logic       irq_o,
  input logic [2:0] win_line_o,
  input logic [7:0] isr_o
);
  p_winner_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_i[win_line_o] && !mask_i[win_line_o]));

  p_winner_not_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !sfn_en_i) |-> !isr_o[win_line_o]);

  p_idle_line_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (win_line_o == 3'd0));

  p_specific_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_data_i[7:5] == 3'd3 && !ack_i) |=> !isr_o[$past(cmd_data_i[2:0])]);

  p_setprio_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && (cmd_data_i[7:5] == 3'd6 || cmd_data_i[7:5] == 3'd2) && !ack_i) |=> $stable(isr_o));

  p_ack_sets_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !aeoi_en_i) |=> isr_o[$past(ack_line_i)]);

  p_aeoi_ack_keeps_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi_en_i && !cmd_we_i) |=> $stable(isr_o));

  p_quiet_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !cmd_we_i) |=> $stable(isr_o));
endmodule

bind irq_prio_resolver irqr_chk u_irqr_chk (.*);

// File: tb/test_irq_prio_resolver.sv
`timescale 1ns/100ps
module test_irq_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_i = '0, mask_i = '0, cmd_data_i = '0;
  logic       cmd_we_i = 1'b0, ack_i = 1'b0, aeoi_en_i = 1'b0, sfn_en_i = 1'b0;
  logic [2:0] ack_line_i = '0;
  logic       irq_o;
  logic [2:0] win_line_o;
  logic [7:0] isr_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_isr;
  logic [2:0] m_base;
  logic       m_rot;

  always #2.5 clk = ~clk;

  irq_prio_resolver i_irq_prio_resolver (.*);

  function automatic int bprio(logic [7:0] v, logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[(p + int'(b)) % 8]) return p;
    return 8;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_isr = '0; m_base = '0; m_rot = 1'b0;
  endtask

  // Called at a negedge with inputs already applied; checks, then advances one clock.
  task automatic step(string tag);
    int rp, cp, p, l;
    logic [7:0] cv, clr;
    logic [2:0] nb, arg;
    logic       nr, exp_irq;
    logic [2:0] exp_line;
    #1;
    rp = bprio(pend_i & ~mask_i, m_base);
    cv = m_isr;
    if (sfn_en_i) cv[2] = 1'b0;
    cp = bprio(cv, m_base);
    exp_irq  = (rp < cp);
    exp_line = exp_irq ? 3'((rp + int'(m_base)) % 8) : 3'd0;
    check(tag, "irq_o", int'(irq_o), int'(exp_irq));
    check(tag, "win_line_o", int'(win_line_o), int'(exp_line));
    check(tag, "isr_o", int'(isr_o), int'(m_isr));
    clr = '0; nb = m_base; nr = m_rot; arg = cmd_data_i[2:0];
    if (cmd_we_i) begin
      case (cmd_data_i[7:5])
        3'd1, 3'd5: begin
          p = bprio(m_isr, m_base);
          if (p < 8) begin
            l = (p + int'(m_base)) % 8;
            clr[l] = 1'b1;
            if (cmd_data_i[7:5] == 3'd5) nb = 3'((l + 1) % 8);
          end
        end
        3'd3: clr[arg] = 1'b1;
        3'd7: begin clr[arg] = 1'b1; nb = arg + 3'd1; end
        3'd6: nb = arg + 3'd1;
        3'd0: nr = 1'b0;
        3'd4: nr = 1'b1;
        default: ;
      endcase
    end
    m_isr = m_isr & ~clr;
    if (ack_i) begin
      if (!aeoi_en_i) m_isr[ack_line_i] = 1'b1;
      if (m_rot) nb = ack_line_i + 3'd1;
    end
    m_base = nb; m_rot = nr;
    @(posedge clk);
    @(negedge clk);
    cmd_we_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d); cmd_we_i = 1'b1; cmd_data_i = d; endtask
  task automatic ack(logic [2:0] l); ack_i = 1'b1; ack_line_i = l; endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R12: reset state
    #1;
    check("R12", "isr after reset", int'(isr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 with base 0: all pending, line 0 wins
    pend_i = 8'hFF; #1;
    check("R1", "winner at base 0", int'(win_line_o), 0);
    step("R12");
    // R2: mask lines 0..2 -> line 3
    mask_i = 8'h07; #1;
    check("R2", "masked winner", int'(win_line_o), 3);
    step("R2");
    // R8: set priority with arg 4 -> base 5, winner line 5
    mask_i = 8'h00; cmd(8'hC4); step("R8");
    #1; check("R8", "winner after base 5", int'(win_line_o), 5);
    step("R1");
    // R8: code 2 no effect
    cmd(8'h40); step("R8");
    // R10: ack line 5 -> isr bit 5, then no irq for less urgent lines
    ack(3'd5); step("R10");
    pend_i = 8'h40; step("R3");
    #1; check("R3", "lower request blocked", int'(irq_o), 0);
    pend_i = 8'h20; step("R3");
    pend_i = 8'h10; step("R3");
    // R5: non-specific EOI clears bit 5
    cmd(8'h20); step("R5");
    #1; check("R5", "isr after non-specific EOI", int'(isr_o), 0);
    cmd(8'h20); step("R5");
    // R4: cascade line 2 in service, nested mode lets line 2 win again
    cmd(8'hC7); step("R8");
    ack(3'd2); step("R10");
    pend_i = 8'h04; sfn_en_i = 1'b1; step("R4");
    #1; check("R4", "cascade re-request", int'(irq_o), 1);
    sfn_en_i = 1'b0; step("R4");
    // R6: rotate on non-specific EOI -> base 3
    cmd(8'hA0); step("R6");
    cmd(8'hA0); step("R6");
    pend_i = 8'hFF; step("R6");
    // R7: specific EOI variants
    ack(3'd6); step("R10");
    ack(3'd1); step("R10");
    cmd(8'h66); step("R7");
    cmd(8'hE1); step("R7");
    // R9: auto-EOI rotation and R10 no isr set under auto-EOI
    aeoi_en_i = 1'b1;
    cmd(8'h80); step("R9");
    ack(3'd4); step("R9");
    #1; check("R9", "winner after auto rotate", int'(win_line_o), 5);
    step("R10");
    cmd(8'h00); step("R9");
    ack(3'd0); step("R9");
    aeoi_en_i = 1'b0;
    // R11: command and acknowledge together
    ack(3'd3); cmd(8'h63); step("R11");
    cmd(8'h80); step("R11");
    ack(3'd2); cmd(8'hC0); step("R11");
    ack(3'd7); cmd(8'h20); step("R11");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      pend_i = 8'($urandom);
      mask_i = 8'($urandom) & 8'($urandom);
      if ((i % 300) == 0) begin
        aeoi_en_i = 1'($urandom);
        sfn_en_i  = 1'($urandom);
      end
      if (($urandom % 4) == 0) cmd(8'($urandom));
      if (($urandom % 3) == 0) begin
        #1;
        ack(irq_o ? win_line_o : 3'($urandom));
      end
      step("R11");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule